// File: doc/BRIEF.md
# Mixed-Depth Pixel Source Selector

This block turns a stream of per-pixel source words into packed 32-bit output colours. Each input pixel carries three things: an 8-bit palette index, a 32-bit true-colour word and a 32-bit control word. The top byte of the control word picks the pixel's source. One tag value selects the true-colour word. Every other value selects the palette entry addressed by the index. In this way indexed and true-colour pixels can be mixed freely within one frame.

The block issues one lookup to an external palette store for every accepted pixel. The store answers with a fixed latency. The true-colour path is delayed by the same number of cycles so that both sources meet at a single selection point. The chosen colour is then packed in RGB or BGR byte order and queued for the output. The stream uses valid/ready handshakes on both sides. Output order always matches input order. An end-of-line marker travels with each pixel.

Top module: `pixsel_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `out_valid` is 0 and `in_ready` is 1.
- R2: A pixel whose `in_ctrl[31:24]` equals 8'h03 is direct: red is `in_direct[23:16]`, green is `in_direct[15:8]` and blue is `in_direct[7:0]`.
- R3: Any other `in_ctrl[31:24]` value selects the palette. In the accept cycle, `pal_rd_en` is 1 and `pal_rd_addr` equals `in_index`. The colour is taken from `pal_rd_data` (red [23:16], green [15:8], blue [7:0]) exactly PAL_LAT cycles later.
- R4: If `cfg_bgr` was 0 when the pixel was accepted, the output is red in [23:16], green in [15:8] and blue in [7:0]. If it was 1, blue is in [23:16] and red is in [7:0]. Green stays in [15:8] in both cases.
- R5: `out_pixel[31:24]` is always 0. `in_direct[31:24]` and `in_ctrl[23:0]` have no effect on the output.
- R6: The block delivers exactly one output per accepted input, in acceptance order. `out_last` repeats the `in_last` of the same pixel.
- R7: A pixel accepted in cycle c can be presented no earlier than cycle c+PAL_LAT+1. `out_valid` is 1 exactly when the oldest undelivered pixel was accepted at least PAL_LAT+1 cycles ago.
- R8: `in_ready` is 1 exactly when fewer than PAL_LAT+2 pixels have been accepted but not yet delivered. While `out_valid` is 1 and `out_ready` is 0, `out_pixel` and `out_last` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bgr | input | 1 | Output byte order: 0 gives RGB, 1 gives BGR |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can take a pixel |
| in_index | input | IDX_W | Palette index |
| in_direct | input | 32 | True-colour word |
| in_ctrl | input | 32 | Control word; the top byte selects the source |
| in_last | input | 1 | Last pixel of the line |
| pal_rd_en | output | 1 | Palette lookup request |
| pal_rd_addr | output | IDX_W | Palette lookup address |
| pal_rd_data | input | 24 | Palette colour, PAL_LAT cycles after the request |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Consumer takes the pixel |
| out_pixel | output | 32 | Packed colour |
| out_last | output | 1 | End-of-line marker of the output pixel |

## Verification
Each result of this block is due at a fixed point in time. The palette lookup goes out in the accept cycle itself. The palette colour is due PAL_LAT cycles after that. The packed pixel may show up no earlier than PAL_LAT+1 cycles after acceptance. The bench's reference model records the cycle in which each pixel was accepted. It then decides, on every falling clock edge, whether `out_valid` must be high that cycle, which pixel and marker must be on the output, and whether `in_ready` must be high given the number of undelivered pixels. Inputs and `out_ready` change just after rising edges. All sampling happens at falling edges, so each comparison sees settled values of the cycle it names.

// File: rtl/pixsel_pkg.sv
package pixsel_pkg;

    localparam int          CH_W       = 8;
    localparam int          PIX_W      = 32;
    localparam logic [7:0]  DIRECT_TAG = 8'h03;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    // Per-pixel state carried alongside the palette lookup
    typedef struct packed {
        logic use_direct;
        logic bgr;
        logic last;
        rgb_t direct;
    } lane_t;

    typedef struct packed {
        logic             last;
        logic [PIX_W-1:0] pixel;
    } outw_t;

    function automatic logic [PIX_W-1:0] pack_pixel(rgb_t c, logic bgr);
        return bgr ? {8'h00, c.b, c.g, c.r} : {8'h00, c.r, c.g, c.b};
    endfunction

    function automatic logic is_direct(logic [PIX_W-1:0] ctrl);
        return ctrl[PIX_W-1 -: 8] == DIRECT_TAG;
    endfunction

endpackage

// File: rtl/pixsel_delay.sv
module pixsel_delay #(
    parameter int STAGES = 2,
    parameter int W      = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    logic [STAGES-1:0] vld_q;
    logic [W-1:0]      data_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else begin
            for (int k = STAGES - 1; k > 0; k--) begin
                vld_q[k] <= vld_q[k-1];
            end
            vld_q[0] <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        for (int k = STAGES - 1; k > 0; k--) begin
            data_q[k] <= data_q[k-1];
        end
        data_q[0] <= in_data;
    end

    assign out_valid = vld_q[STAGES-1];
    assign out_data  = data_q[STAGES-1];
endmodule

// File: rtl/pixsel_fifo.sv
module pixsel_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic         nonempty,
    output logic [W-1:0] rdata
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            if (push && !pop)      count <= count + CW'(1);
            else if (pop && !push) count <= count - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    assign nonempty = (count != '0);
    assign rdata    = mem[rd_ptr];
endmodule

// File: rtl/pixsel_top.sv
module pixsel_top
    import pixsel_pkg::*;
#(
    parameter int PAL_LAT = 2,
    parameter int IDX_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_bgr,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IDX_W-1:0] in_index,
    input  logic [31:0]      in_direct,
    input  logic [31:0]      in_ctrl,
    input  logic             in_last,
    output logic             pal_rd_en,
    output logic [IDX_W-1:0] pal_rd_addr,
    input  logic [23:0]      pal_rd_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [31:0]      out_pixel,
    output logic             out_last
);
    localparam int DEPTH  = PAL_LAT + 2;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int LANE_W = $bits(lane_t);
    localparam int OUT_W  = $bits(outw_t);

    logic             accept, deliver;
    logic [CNT_W-1:0] pending;
    lane_t            lane_in, lane_out;
    logic [LANE_W-1:0] lane_out_bits;
    logic             lane_out_vld;
    rgb_t             chosen;
    outw_t            fifo_in, fifo_out;
    logic [OUT_W-1:0] fifo_out_bits;
    logic             unused_bits;

    assign unused_bits = ^{in_ctrl[23:0], in_direct[31:24]};

    // Credit rule: never admit more pixels than the output queue can hold
    assign in_ready = (pending < CNT_W'(DEPTH));
    assign accept   = in_valid && in_ready;
    assign deliver  = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
        end else if (accept && !deliver) begin
            pending <= pending + CNT_W'(1);
        end else if (deliver && !accept) begin
            pending <= pending - CNT_W'(1);
        end
    end

    assign pal_rd_en   = accept;
    assign pal_rd_addr = in_index;

    always_comb begin
        lane_in.use_direct = is_direct(in_ctrl);
        lane_in.bgr        = cfg_bgr;
        lane_in.last       = in_last;
        lane_in.direct     = rgb_t'(in_direct[23:0]);
    end

    pixsel_delay #(
        .STAGES (PAL_LAT),
        .W      (LANE_W)
    ) u_align (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (accept),
        .in_data   (lane_in),
        .out_valid (lane_out_vld),
        .out_data  (lane_out_bits)
    );

    assign lane_out = lane_t'(lane_out_bits);

    always_comb begin
        chosen        = lane_out.use_direct ? lane_out.direct : rgb_t'(pal_rd_data);
        fifo_in.last  = lane_out.last;
        fifo_in.pixel = pack_pixel(chosen, lane_out.bgr);
    end

    pixsel_fifo #(
        .DEPTH (DEPTH),
        .W     (OUT_W)
    ) u_outq (
        .clk      (clk),
        .rst      (rst),
        .push     (lane_out_vld),
        .wdata    (fifo_in),
        .pop      (deliver),
        .nonempty (out_valid),
        .rdata    (fifo_out_bits)
    );

    assign fifo_out  = outw_t'(fifo_out_bits);
    assign out_pixel = fifo_out.pixel;
    assign out_last  = fifo_out.last;
endmodule

// File: rtl/pixsel_checker.sv
module pixsel_checker #(
    parameter int PAL_LAT = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_pixel,
    input logic        out_last
);
    localparam int LIMIT = PAL_LAT + 2;

    int unsigned owed;

    always_ff @(posedge clk) begin
        if (rst) begin
            owed <= 0;
        end else begin
            owed <= owed + ((in_valid && in_ready) ? 1 : 0)
                         - ((out_valid && out_ready) ? 1 : 0);
        end
    end

    // R1: idle and open right after reset
    p_idle_after_reset_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready));

    // R5: upper byte always clear
    p_top_byte_zero_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_pixel[31:24] == 8'h00));

    // R6: nothing emitted without an accepted pixel behind it
    p_no_phantom_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (owed != 0));

    // R8: admission closes at the limit
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        (owed >= LIMIT) |-> !in_ready);

    // R8: stalled output holds
    p_hold_stalled_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_pixel) && $stable(out_last)));
endmodule

bind pixsel_top pixsel_checker #(.PAL_LAT(PAL_LAT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pixel (out_pixel),
    .out_last  (out_last)
);

// File: tb/tb_pixsel_top.sv
module tb_pixsel_top;
    localparam int CLK_PERIOD = 10;
    localparam int PAL_LAT    = 2;
    localparam int LIMIT      = PAL_LAT + 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_bgr = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_index = '0;
    logic [31:0] in_direct = '0;
    logic [31:0] in_ctrl = '0;
    logic        in_last = 1'b0;
    logic        pal_rd_en;
    logic [7:0]  pal_rd_addr;
    logic [23:0] pal_rd_data;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_pixel;
    logic        out_last;

    int checks = 0;
    int fails  = 0;
    int cycle  = 0;
    int ready_mode = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] px;
        logic        last;
        int          cyc;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pixsel_top #(.PAL_LAT(PAL_LAT), .IDX_W(8)) dut (
        .clk(clk), .rst(rst), .cfg_bgr(cfg_bgr),
        .in_valid(in_valid), .in_ready(in_ready), .in_index(in_index),
        .in_direct(in_direct), .in_ctrl(in_ctrl), .in_last(in_last),
        .pal_rd_en(pal_rd_en), .pal_rd_addr(pal_rd_addr), .pal_rd_data(pal_rd_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_pixel(out_pixel), .out_last(out_last)
    );

    // Palette store model with fixed read latency
    function automatic logic [23:0] pal_val(logic [7:0] i);
        return {i ^ 8'h5A, i + 8'd17, ~i};
    endfunction

    logic [23:0] pal_pipe [PAL_LAT];
    always @(posedge clk) begin
        for (int k = PAL_LAT - 1; k > 0; k--) pal_pipe[k] <= pal_pipe[k-1];
        pal_pipe[0] <= pal_rd_en ? pal_val(pal_rd_addr) : 24'hA5A5A5;
    end
    assign pal_rd_data = pal_pipe[PAL_LAT-1];

    function automatic exp_t model(logic [7:0] idx, logic [31:0] dir,
                                   logic [31:0] ctl, logic bgr, logic last);
        exp_t e;
        logic [23:0] c;
        if (ctl[31:24] == 8'h03) begin
            c = dir[23:0];
            e.tag = "R2";
        end else begin
            c = pal_val(idx);
            e.tag = "R3";
        end
        if (bgr) begin
            e.px = {8'h00, c[7:0], c[15:8], c[23:16]};
            e.tag = {e.tag, " R4"};
        end else begin
            e.px = {8'h00, c};
        end
        e.last = last;
        e.cyc = 0;
        return e;
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cycle);
        end
    endtask

    // Cycle-by-cycle monitor and reference model
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit exp_valid;
            exp_t e;
            exp_valid = (q.size() > 0) && (cycle - q[0].cyc >= PAL_LAT + 1);
            check(in_ready == (q.size() < LIMIT), "R8", "in_ready",
                  {31'd0, in_ready}, {31'd0, q.size() < LIMIT});
            check(out_valid == exp_valid, "R7", "out_valid",
                  {31'd0, out_valid}, {31'd0, exp_valid});
            if (out_valid && exp_valid) begin
                check(out_pixel == q[0].px, q[0].tag, "out_pixel", out_pixel, q[0].px);
                check(out_pixel[31:24] == 8'h00, "R5", "top byte",
                      {24'd0, out_pixel[31:24]}, 32'd0);
                check(out_last == q[0].last, "R6", "out_last",
                      {31'd0, out_last}, {31'd0, q[0].last});
                if (out_ready) void'(q.pop_front());
            end
            if (in_valid && in_ready) begin
                check(pal_rd_en && pal_rd_addr == in_index, "R3", "lookup request",
                      {23'd0, pal_rd_en, pal_rd_addr}, {23'd0, 1'b1, in_index});
                e = model(in_index, in_direct, in_ctrl, cfg_bgr, in_last);
                e.cyc = cycle;
                q.push_back(e);
            end
            cycle++;
        end
    end

    // out_ready driver
    always @(posedge clk) begin
        #1;
        case (ready_mode)
            0: out_ready = 1'b1;
            1: out_ready = ($urandom_range(0, 2) != 0);
            default: out_ready = 1'b0;
        endcase
    end

    task automatic send(logic [7:0] idx, logic [31:0] dir, logic [31:0] ctl,
                        logic bgr, logic last, int gap);
        bit acc;
        in_valid = 1'b1; in_index = idx; in_direct = dir; in_ctrl = ctl;
        cfg_bgr = bgr; in_last = last;
        do begin
            @(negedge clk);
            acc = in_ready;
            @(posedge clk); #1;
        end while (!acc);
        in_valid = 1'b0;
        in_index = $urandom; in_direct = $urandom; in_ctrl = $urandom;
        for (int g = 0; g < gap; g++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic drain();
        int guard = 0;
        while (q.size() > 0 && guard < 1000) begin
            @(posedge clk); #1;
            guard++;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state while held in reset
        check(out_valid == 1'b0, "R1", "out_valid in reset", {31'd0, out_valid}, 32'd0);
        check(in_ready == 1'b1, "R1", "in_ready in reset", {31'd0, in_ready}, 32'd1);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", {31'd0, out_valid}, 32'd0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", {31'd0, in_ready}, 32'd1);
        @(posedge clk); #1;

        // R3 R7: palette pixels back to back, RGB
        for (int i = 0; i < 16; i++)
            send(8'(i * 17), 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, i == 15, 0);
        drain();

        // R2 R5: direct pixels with noise in ignored bits
        for (int i = 0; i < 16; i++)
            send(8'(i), {8'(i * 29), 24'(i * 32'h0102_03)}, {8'h03, 24'($urandom)},
                 1'b0, i == 15, i % 2);
        drain();

        // R2 R3: tag values next to the direct tag select the palette
        send(8'h00, 32'h12_345678, 32'h0200_0000, 1'b0, 1'b0, 0);
        send(8'hFF, 32'h00_ABCDEF, 32'h0700_0000, 1'b0, 1'b0, 0);
        send(8'h80, 32'h00_111111, 32'h8300_0000, 1'b0, 1'b0, 0);
        send(8'h7F, 32'h00_222222, 32'h1300_0000, 1'b0, 1'b0, 0);
        send(8'h40, 32'h00_333333, 32'h0300_0000, 1'b0, 1'b1, 0);
        drain();

        // R4: byte order switched pixel by pixel, mixed sources
        for (int i = 0; i < 20; i++)
            send(8'($urandom), $urandom, (i % 3 == 0) ? 32'h0300_0000 : $urandom,
                 1'(i % 2), i == 19, 0);
        drain();

        // R8: output stalled, admission must close at the limit
        ready_mode = 2;
        fork
            for (int i = 0; i < LIMIT + 3; i++)
                send(8'(i + 3), 32'h00_C0FFEE + 32'(i), (i % 2) ? 32'h0300_0000 : 32'h0, 1'b1, 1'b0, 0);
            begin
                repeat (20) @(posedge clk);
                #1 ready_mode = 0;
            end
        join
        drain();

        // R6 R8: random backpressure and random gaps
        ready_mode = 1;
        for (int i = 0; i < 300; i++)
            send(8'($urandom), $urandom, ($urandom_range(0, 1) != 0) ? {8'h03, 24'($urandom)} : $urandom,
                 1'($urandom), ($urandom_range(0, 7) == 0), $urandom_range(0, 2));
        ready_mode = 0;
        drain();
        repeat (4) @(posedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule